// File: doc/BRIEF.md
# Serial Clock Rate Generator with Settle Flag

This block derives a serial clock from the base clock through an 8-bit programmable divider. The serial clock has a period of twice the divider value in base clock cycles, so its frequency is the base frequency over twice the divider. A small control word holds an enable bit, a read-only settle flag and the divider field. Software writes the control word and polls the settle flag. The flag tells software when a new divider value is actually driving the pin.

While the block is running, a divider change never cuts a period short. The new value is loaded only when a full period ends, which is when the output goes back to its idle level. The settle flag drops on the write that changes the divider. It comes back one full period after the new rate has started. The idle level, and so the clock polarity, comes from a separate input. While the block is disabled, the output rests at that idle level.

Top module: `sck_rate_gen`

## Requirements
- R1: After reset the control word reads enable 0, settle flag 1, divider equal to the reset divider (default 1, giving 16'h0102), and the serial clock sits at its idle level.
- R2: The control word places enable at bit 0 (read/write), the settle flag at bit 1 (read-only; written values are ignored) and the divider at bits 15:8 (read/write). All other bits read 0.
- R3: While enable is 0, the serial clock equals `idle_hi_i`: high when it is 1 and low when it is 0.
- R4: A write that sets enable from the disabled state starts the clock at the written divider D. The clock stays at idle for D samples after the write edge, then at the active level for D cycles, then idles for D cycles, and so on (period 2·D).
- R5: A divider value of 0 behaves exactly like a divider of 1.
- R6: While enabled, a write whose divider field differs from the stored divider clears the settle flag, as seen on the cycle after the write. A write of the same divider leaves the flag at 1.
- R7: While enabled, a new divider takes effect only at the next full-period boundary (the return to idle level). The period in progress completes at the old rate.
- R8: After a divider change while enabled, the settle flag reads 1 again from the cycle after the first complete period at the new rate ends.
- R9: While disabled, a divider write takes effect at once and the settle flag stays 1.
- R10: With `idle_hi_i` at 1, the running waveform is the inverse of the one produced with `idle_hi_i` at 0, with the same half-period lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 16 | Control word write data |
| cfg_rdata_o | output | 16 | Control word read data (enable, settle flag, divider) |
| idle_hi_i | input | 1 | Idle level of the serial clock (polarity) |
| sck_o | output | 1 | Serial clock output |

## Verification
The assertions assume two things about the inputs. First, `idle_hi_i` only changes while the clock is disabled. Second, writes arrive as single-cycle strobes with settled data. The stimulus sets the polarity before each enable write and drives every input on the falling clock edge. Several properties depend on the enable and divider being sampled at the same edge as the write. These are the rule that the divider changes only at a boundary or while disabled, and the rule that the settle flag rises only at a boundary. The bench keeps writes away from reset release so that those pairs line up.

// File: rtl/sck_rate_pkg.sv
package sck_rate_pkg;
   typedef enum logic {
      HALF_IDLE   = 1'b0,
      HALF_ACTIVE = 1'b1
   } half_e;
endpackage

// File: rtl/sck_cfg_reg.sv
module sck_cfg_reg #(
   parameter int REG_W   = 16,
   parameter int DIV_W   = 8,
   parameter int DIV_LSB = 8,
   parameter int EN_BIT  = 0,
   parameter int RST_DIV = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic             en_o,
   output logic [DIV_W-1:0] div_o,
   output logic [DIV_W-1:0] div_nxt_o,
   output logic             div_chg_o
);
   logic [DIV_W-1:0] wr_div;
   logic             en_q;
   logic [DIV_W-1:0] div_q;

   assign wr_div    = wdata_i[DIV_LSB +: DIV_W];
   assign div_nxt_o = we_i ? wr_div : div_q;
   assign div_chg_o = we_i && (wr_div != div_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= 1'b0;
         div_q <= DIV_W'(RST_DIV);
      end else if (we_i) begin
         en_q  <= wdata_i[EN_BIT];
         div_q <= wr_div;
      end
   end

   assign en_o  = en_q;
   assign div_o = div_q;

   assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (div_q == $past(wr_div)) && (en_q == $past(wdata_i[EN_BIT])));
endmodule

// File: rtl/sck_half_engine.sv
module sck_half_engine
   import sck_rate_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int RST_DIV = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_nxt_i,
   input  logic             div_chg_i,
   output half_e            half_o,
   output logic             stable_o
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
   localparam logic [DIV_W-1:0] RST_EFF = (RST_DIV == 0) ? ONE : DIV_W'(RST_DIV);

   function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
      return (d == '0) ? ONE : d;
   endfunction

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] act_q;
   half_e            half_q;
   logic             pend_q;
   logic             settle_q;
   logic             stable_q;
   logic             wrap;
   logic             bnd;
   logic             pend_eff;

   assign wrap     = (cnt_q == act_q - ONE);
   assign bnd      = wrap && (half_q == HALF_ACTIVE);
   assign pend_eff = pend_q || div_chg_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         act_q    <= RST_EFF;
         half_q   <= HALF_IDLE;
         pend_q   <= 1'b0;
         settle_q <= 1'b0;
         stable_q <= 1'b1;
      end else if (!en_i) begin
         cnt_q    <= '0;
         half_q   <= HALF_IDLE;
         act_q    <= eff_div(div_nxt_i);
         pend_q   <= 1'b0;
         settle_q <= 1'b0;
         stable_q <= 1'b1;
      end else begin
         if (wrap) begin
            cnt_q  <= '0;
            half_q <= (half_q == HALF_IDLE) ? HALF_ACTIVE : HALF_IDLE;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
         if (bnd) begin
            if (pend_eff) begin
               act_q    <= eff_div(div_nxt_i);
               pend_q   <= 1'b0;
               settle_q <= 1'b1;
               stable_q <= 1'b0;
            end else if (settle_q) begin
               settle_q <= 1'b0;
               stable_q <= 1'b1;
            end
         end else if (div_chg_i) begin
            pend_q   <= 1'b1;
            settle_q <= 1'b0;
            stable_q <= 1'b0;
         end
      end
   end

   assign half_o   = half_q;
   assign stable_o = stable_q;

   assert_cnt_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < act_q);
   assert_div_never_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_q != '0);
   assert_change_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && div_chg_i) |=> !stable_q);
   assert_div_at_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_q) |-> ($past(bnd) || $past(!en_i)));
   assert_settle_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stable_q) |-> ($past(bnd) || $past(!en_i)));
   assert_idle_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> stable_q);
endmodule

// File: rtl/sck_out_stage.sv
module sck_out_stage
   import sck_rate_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  en_i,
   input  half_e half_i,
   input  logic  idle_hi_i,
   output logic  sck_o
);
   logic sck_d;

   assign sck_d = (en_i && (half_i == HALF_ACTIVE)) ? !idle_hi_i : idle_hi_i;

   generate
      if (OUT_REG) begin : g_flop
         logic sck_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sck_q <= 1'b0;
            else         sck_q <= sck_d;
         end
         assign sck_o = sck_q;
      end else begin : g_direct
         assign sck_o = sck_d;
         assert_idle_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i |-> (sck_o == idle_hi_i));
      end
   endgenerate
endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
   import sck_rate_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter int DIV_W   = 8,
   parameter int DIV_LSB = 8,
   parameter int EN_BIT  = 0,
   parameter int STB_BIT = 1,
   parameter int RST_DIV = 1,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cfg_we_i,
   input  logic [REG_W-1:0] cfg_wdata_i,
   output logic [REG_W-1:0] cfg_rdata_o,
   input  logic             idle_hi_i,
   output logic             sck_o
);
   localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

   generate
      if (DIV_W < 1) begin : g_bad_width
         $error("divider width must be at least 1");
      end
      if (DIV_MSB >= REG_W) begin : g_bad_field
         $error("divider field exceeds control word");
      end
      if (EN_BIT == STB_BIT || EN_BIT >= REG_W || STB_BIT >= REG_W) begin : g_bad_bits
         $error("enable and settle bits must be distinct and inside the word");
      end
      if ((EN_BIT >= DIV_LSB && EN_BIT <= DIV_MSB) ||
          (STB_BIT >= DIV_LSB && STB_BIT <= DIV_MSB)) begin : g_overlap
         $error("single-bit fields overlap the divider field");
      end
      if (RST_DIV < 0 || RST_DIV >= (1 << DIV_W)) begin : g_bad_rst
         $error("reset divider does not fit the divider field");
      end
   endgenerate

   logic             en;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_nxt;
   logic             div_chg;
   half_e            half;
   logic             stable;

   sck_cfg_reg #(
      .REG_W(REG_W), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB),
      .EN_BIT(EN_BIT), .RST_DIV(RST_DIV)
   ) i_cfg (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
      .en_o(en), .div_o(div_q), .div_nxt_o(div_nxt), .div_chg_o(div_chg)
   );

   sck_half_engine #(
      .DIV_W(DIV_W), .RST_DIV(RST_DIV)
   ) i_engine (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .div_nxt_i(div_nxt),
      .div_chg_i(div_chg), .half_o(half), .stable_o(stable)
   );

   sck_out_stage #(
      .OUT_REG(OUT_REG)
   ) i_out (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .half_i(half),
      .idle_hi_i(idle_hi_i), .sck_o(sck_o)
   );

   always_comb begin
      cfg_rdata_o                     = '0;
      cfg_rdata_o[EN_BIT]             = en;
      cfg_rdata_o[STB_BIT]            = stable;
      cfg_rdata_o[DIV_LSB +: DIV_W]   = div_q;
   end

   assert_same_write_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && en && stable &&
       (cfg_wdata_i[DIV_LSB +: DIV_W] == div_q) && cfg_wdata_i[EN_BIT]) |=> stable);
endmodule

// File: tb/test_sck_rate_gen.sv
`timescale 1ns/1ps
module test_sck_rate_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        idle_hi = 1'b0;
   logic        sck;

   int checks = 0;
   int fails  = 0;
   logic sck_s [10];
   logic stb_s [10];

   always #2 clk = ~clk;

   sck_rate_gen i_sck_rate_gen (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
      .cfg_rdata_o(rdata), .idle_hi_i(idle_hi), .sck_o(sck)
   );

   // [8] idle level, [7:0] divider
   localparam logic [8:0] VEC [6] = '{
      {1'b0, 8'd1}, {1'b0, 8'd3}, {1'b1, 8'd2},
      {1'b0, 8'd0}, {1'b1, 8'd5}, {1'b1, 8'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] d);
      we    = 1'b1;
      wdata = d;
      tick();
      we    = 1'b0;
   endtask

   task automatic run_len(input logic lvl, output int n);
      n = 0;
      for (int i = 0; i < 1000; i++) begin
         if (sck != lvl) break;
         n++;
         tick();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n;
      int d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 rdata", rdata, 16'h0102);
      chk("R1 sck idle", sck, 0);

      // table walk: R4 R5 R10
      foreach (VEC[v]) begin
         idle_hi = VEC[v][8];
         d = (VEC[v][7:0] == 8'd0) ? 1 : int'(VEC[v][7:0]);
         tick();
         wr({VEC[v][7:0], 8'h01});
         run_len(idle_hi, n);
         chk($sformatf("R4 R5 R10 vec%0d first idle", v), n, d);
         run_len(!idle_hi, n);
         chk($sformatf("R4 R5 R10 vec%0d active half", v), n, d);
         run_len(idle_hi, n);
         chk($sformatf("R4 R10 vec%0d idle half", v), n, d);
         chk($sformatf("R9 vec%0d flag after enable", v), rdata[1], 1);
         wr({VEC[v][7:0], 8'h00});
         chk($sformatf("R3 vec%0d idle after disable", v), sck, idle_hi);
      end

      // R3 polarity while disabled
      idle_hi = 1'b1; tick();
      chk("R3 idle high", sck, 1);
      idle_hi = 1'b0; tick();
      chk("R3 idle low", sck, 0);

      // R2 field layout, settle bit read-only
      wr(16'hFFFF);
      chk("R2 all ones", rdata, 16'hFF03);
      wr(16'h0000);
      tick();
      chk("R2 all zero", rdata, 16'h0002);

      // R9 divider write while disabled keeps flag
      wr(16'h0700);
      chk("R9 flag stays", rdata[1], 1);
      chk("R9 divider stored", rdata[15:8], 7);

      // R6 same-value write keeps flag
      wr(16'h0201);
      repeat (3) tick();
      wr(16'h0201);
      chk("R6 same value keeps flag", rdata[1], 1);

      // R7 R8 change at boundary, old period completes
      for (int i = 0; i < 20; i++) begin
         if (sck == 1'b1) break;
         tick();
      end
      wr(16'h0301);
      sck_s[1] = sck; stb_s[1] = rdata[1];
      chk("R6 change clears flag", stb_s[1], 0);
      chk("R7 old active half continues", sck_s[1], 1);
      for (int k = 2; k <= 8; k++) begin
         tick();
         sck_s[k] = sck; stb_s[k] = rdata[1];
      end
      for (int k = 2; k <= 4; k++) chk($sformatf("R7 new idle k%0d", k), sck_s[k], 0);
      for (int k = 5; k <= 7; k++) chk($sformatf("R7 new active k%0d", k), sck_s[k], 1);
      chk("R7 boundary k8", sck_s[8], 0);
      chk("R8 flag low before settle", stb_s[7], 0);
      chk("R8 flag set after full period", stb_s[8], 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule